// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is the serial front end of a register-mapped peripheral. It watches a two-wire bus (clock and data lines, both idling high), spots the start and stop conditions, shifts in bytes and acknowledges them by pulling the data line low in the ninth clock. It answers to one seven-bit address. The upper three bits of that address are a fixed prefix. The lower four bits come from two select pins, and each pin can be tied low, tied high, wired to the bus clock or wired to the bus data line. Every line is oversampled by a system clock that runs at least eight times faster than the bus clock.

After a write address, the first byte sets an internal register pointer. Any further bytes are written to the register at that pointer, and the pointer steps forward by one after each byte. The pointer persists between transactions. A read transaction returns bytes starting at the stored pointer and advances it after each byte. A write that carries only the pointer byte and then ends touches no register. Toward the register file the block offers a plain bus: an address (the pointer), write data, a one-cycle write strobe, a one-cycle read strobe, and read data that the register file returns in the cycle of the read strobe.

Top module: `i2c_reg_slave`

## Requirements
- R1: A falling data line while the clock line is high is a start condition, and a rising data line while the clock line is high is a stop condition. After a stop the slave releases the data line and returns to idle.
- R2: The device address is the prefix 100 followed by four select bits, sent most significant bit first and followed by a direction bit (0 = write, 1 = read). On a match the slave holds `sda_oe_o` high through the ninth clock, so the line reads 0 at the master's ack sample.
- R3: On an address mismatch the slave gives no acknowledge and ignores every later byte until the next start: no acknowledge and no write strobe.
- R4: Each select pin decodes to a two-bit code: tied low = 0, tied high = 1, wired to the clock line = 2, wired to the data line = 3. `sel_pins_i[1]` supplies address bits 3:2 and `sel_pins_i[0]` supplies bits 1:0.
- R5: The first byte after a write address is loaded into the pointer and acknowledged. When a stop follows it, no register is written.
- R6: Each further write byte is acknowledged and written to the register at the pointer. The pointer then advances by one and wraps from 0xFF to 0x00.
- R7: A read sends, most significant bit first, the register at the stored pointer. The pointer advances after each byte is fetched. Reading continues while the master acknowledges and stops after a master not-acknowledge.
- R8: A repeated start after the pointer byte, followed by a read address, keeps the pointer, so the read starts at the register just selected.
- R9: The write strobe and the read strobe each last exactly one system cycle, never occur together, and present the current pointer on `reg_addr_o`.
- R10: While the clock line stays high, the slave changes `sda_oe_o` only in response to a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High pulls the data line low (open drain) |
| sel_pins_i | input | 2 | Address select pins; bit 1 feeds address bits 3:2 |
| reg_addr_o | output | 8 | Register pointer presented to the register file |
| reg_wdata_o | output | 8 | Write data, valid with the write strobe |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Register contents at `reg_addr_o`, taken during the read strobe |

## Verification
Assertions check on every cycle that a stop condition leads to idle with the data line released, that each strobe lasts a single cycle and neither coincides with the other, that the pointer advances by exactly one after every strobe, and that the slave never moves the data line while the clock is high unless a start or stop has just occurred. The bench alone can show the end-to-end behaviour. That covers the address decode for each kind of pin wiring, acknowledge versus silence, the data that actually lands in the register file, pointer persistence across stops and repeated starts, wrap-around, and the read byte order seen on the wire.

// File: rtl/i2c_reg_slave_pkg.sv
package i2c_reg_slave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_DATA,
        ST_ACK,
        ST_TX,
        ST_RACK
    } bus_st_e;

    typedef enum logic [1:0] {
        AK_WR,
        AK_RD,
        AK_CMD,
        AK_DATA
    } ack_e;

    localparam logic [1:0] PIN_GND = 2'd0;
    localparam logic [1:0] PIN_VDD = 2'd1;
    localparam logic [1:0] PIN_SCL = 2'd2;
    localparam logic [1:0] PIN_SDA = 2'd3;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '1;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_pin_decode.sv
module i2c_pin_decode
    import i2c_reg_slave_pkg::*;
#(
    parameter int PINS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   pin_s_i,
    input  logic              scl_s_i,
    input  logic              sda_s_i,
    output logic [2*PINS-1:0] code_o
);
    // A flag latches once a pin has been seen at a level other than the
    // clock (or data) line. A pin that never differs is wired to that line.
    logic [PINS-1:0] miss_scl_d, miss_scl_q;
    logic [PINS-1:0] miss_sda_d, miss_sda_q;

    always_comb begin
        miss_scl_d = miss_scl_q | (pin_s_i ^ {PINS{scl_s_i}});
        miss_sda_d = miss_sda_q | (pin_s_i ^ {PINS{sda_s_i}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miss_scl_q <= '0;
            miss_sda_q <= '0;
        end else begin
            miss_scl_q <= miss_scl_d;
            miss_sda_q <= miss_sda_d;
        end
    end

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        assign code_o[2*g +: 2] = !miss_scl_q[g] ? PIN_SCL :
                                  !miss_sda_q[g] ? PIN_SDA :
                                  pin_s_i[g]     ? PIN_VDD : PIN_GND;
    end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_reg_slave_pkg::*;
#(
    parameter int                  SYNC_STAGES = 2,
    parameter int                  SEL_PINS    = 2,
    parameter logic [6-2*SEL_PINS:0] ADDR_PREFIX = 3'b100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe_o,
    input  logic [SEL_PINS-1:0] sel_pins_i,
    output logic [7:0]          reg_addr_o,
    output logic [7:0]          reg_wdata_o,
    output logic                reg_we_o,
    output logic                reg_re_o,
    input  logic [7:0]          reg_rdata_i
);
    localparam int LOW_W   = 2 * SEL_PINS;
    localparam int LINES   = 2 + SEL_PINS;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        bus_st_e           st;
        ack_e              ak;
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] ptr;
        logic [BYTE_W-1:0] wdata;
        logic              oe;
        logic              more;
        logic              we;
        logic              re;
        logic              scl_p;
        logic              sda_p;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, ak: AK_WR, sh: '0, cnt: '0,
                                 ptr: '0, wdata: '0, oe: 1'b0, more: 1'b0,
                                 we: 1'b0, re: 1'b0, scl_p: 1'b1, sda_p: 1'b1};

    logic [LINES-1:0] lines_s;
    logic             scl_s, sda_s;
    logic [LOW_W-1:0] low_bits;
    logic [6:0]       own_addr;
    logic             scl_rise, scl_fall, start_det, stop_det;
    ctl_t             c_q, c_d;

    i2c_line_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sel_pins_i, sda_i, scl_i}),
        .q_o   (lines_s)
    );

    assign scl_s = lines_s[0];
    assign sda_s = lines_s[1];

    i2c_pin_decode #(.PINS(SEL_PINS)) i_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_s_i (lines_s[LINES-1:2]),
        .scl_s_i (scl_s),
        .sda_s_i (sda_s),
        .code_o  (low_bits)
    );

    assign own_addr  = {ADDR_PREFIX, low_bits};
    assign scl_rise  = scl_s & ~c_q.scl_p;
    assign scl_fall  = ~scl_s & c_q.scl_p;
    assign start_det = scl_s & c_q.scl_p & c_q.sda_p & ~sda_s;
    assign stop_det  = scl_s & c_q.scl_p & ~c_q.sda_p & sda_s;

    always_comb begin
        c_d       = c_q;
        c_d.we    = 1'b0;
        c_d.re    = 1'b0;
        c_d.scl_p = scl_s;
        c_d.sda_p = sda_s;
        if (c_q.we || c_q.re) begin
            c_d.ptr = c_q.ptr + 1'b1;
        end
        if (start_det) begin
            c_d.st  = ST_ADDR;
            c_d.cnt = '0;
            c_d.oe  = 1'b0;
        end else if (stop_det) begin
            c_d.st  = ST_IDLE;
            c_d.cnt = '0;
            c_d.oe  = 1'b0;
        end else begin
            unique case (c_q.st)
                ST_ADDR, ST_CMD, ST_DATA: begin
                    if (scl_rise && c_q.cnt != LAST_RX) begin
                        c_d.sh  = {c_q.sh[BYTE_W-2:0], sda_s};
                        c_d.cnt = c_q.cnt + 1'b1;
                    end else if (scl_fall && c_q.cnt == LAST_RX) begin
                        c_d.cnt = '0;
                        c_d.st  = ST_ACK;
                        c_d.oe  = 1'b1;
                        if (c_q.st == ST_ADDR) begin
                            if (c_q.sh[7:1] == own_addr) begin
                                c_d.ak = c_q.sh[0] ? AK_RD : AK_WR;
                            end else begin
                                c_d.st = ST_IDLE;
                                c_d.oe = 1'b0;
                            end
                        end else if (c_q.st == ST_CMD) begin
                            c_d.ptr = c_q.sh;
                            c_d.ak  = AK_CMD;
                        end else begin
                            c_d.we    = 1'b1;
                            c_d.wdata = c_q.sh;
                            c_d.ak    = AK_DATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        c_d.oe = 1'b0;
                        unique case (c_q.ak)
                            AK_WR:   c_d.st = ST_CMD;
                            AK_RD:   begin c_d.st = ST_TX; c_d.re = 1'b1; end
                            default: c_d.st = ST_DATA;
                        endcase
                    end
                end
                ST_TX: begin
                    if (c_q.re) begin
                        c_d.sh = reg_rdata_i;
                        c_d.oe = ~reg_rdata_i[BYTE_W-1];
                    end else if (scl_fall) begin
                        if (c_q.cnt == LAST_TX) begin
                            c_d.st  = ST_RACK;
                            c_d.oe  = 1'b0;
                            c_d.cnt = '0;
                        end else begin
                            c_d.sh  = {c_q.sh[BYTE_W-2:0], 1'b0};
                            c_d.cnt = c_q.cnt + 1'b1;
                            c_d.oe  = ~c_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        c_d.more = ~sda_s;
                    end else if (scl_fall) begin
                        if (c_q.more) begin
                            c_d.st = ST_TX;
                            c_d.re = 1'b1;
                        end else begin
                            c_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= CTL_RST;
        else        c_q <= c_d;
    end

    assign sda_oe_o    = c_q.oe;
    assign reg_addr_o  = c_q.ptr;
    assign reg_wdata_o = c_q.wdata;
    assign reg_we_o    = c_q.we;
    assign reg_re_o    = c_q.re;

    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (c_q.st == ST_IDLE) && !sda_oe_o);

    assert_we_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);

    assert_re_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re_o |=> !reg_re_o);

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we_o && reg_re_o));

    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> reg_addr_o == $past(reg_addr_o) + 8'd1);

    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re_o |=> reg_addr_o == $past(reg_addr_o) + 8'd1);

    assert_sda_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && c_q.scl_p && !$past(start_det) && !$past(stop_det))
            |-> $stable(sda_oe_o));
endmodule

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [1:0] sel_pins;
    logic [1:0] pcfg1, pcfg0;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we, reg_re;
    logic [7:0] regs [256];
    int         n_chk = 0;
    int         n_fail = 0;
    int         we_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    // Pin wiring codes: 0 tied low, 1 tied high, 2 clock line, 3 data line
    always_comb begin
        case (pcfg1)
            2'd0: sel_pins[1] = 1'b0;
            2'd1: sel_pins[1] = 1'b1;
            2'd2: sel_pins[1] = scl_m;
            default: sel_pins[1] = sda_line;
        endcase
        case (pcfg0)
            2'd0: sel_pins[0] = 1'b0;
            2'd1: sel_pins[0] = 1'b1;
            2'd2: sel_pins[0] = scl_m;
            default: sel_pins[0] = sda_line;
        endcase
    end

    i2c_reg_slave i_i2c_reg_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .sel_pins_i  (sel_pins),
        .reg_addr_o  (reg_addr),
        .reg_wdata_o (reg_wdata),
        .reg_we_o    (reg_we),
        .reg_re_o    (reg_re),
        .reg_rdata_i (reg_rdata)
    );

    assign reg_rdata = regs[reg_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) regs[i] <= 8'(i) ^ 8'h5A;
        end else if (reg_we) begin
            regs[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] c1, input logic [1:0] c0);
        pcfg1 = c1;
        pcfg0 = c0;
        scl_m = 1'b1;
        sda_m = 1'b1;
        rst_n = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(4);
    endtask

    task automatic m_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic m_write(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_read(input logic nak, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(2*Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line; tick(Q);
            scl_m = 1'b0;
        end
        sda_m = nak; tick(2*Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0;
    endtask

    task automatic t_reset_state;
        chk(sda_oe == 1'b0, "R1 data line released after reset", int'(sda_oe), 0);
        chk(reg_we == 1'b0 && reg_re == 1'b0, "R9 no strobe after reset",
            int'({reg_we, reg_re}), 0);
    endtask

    // Pins: high pin on data line (3), low pin on clock line (2) -> 0x4E
    task automatic t_write_burst;
        logic a;
        int   w0;
        w0 = we_cnt;
        m_start;
        m_write(8'h9C, a); chk(a == 1'b0, "R2 address ack", int'(a), 0);
        m_write(8'h10, a); chk(a == 1'b0, "R5 pointer byte ack", int'(a), 0);
        m_write(8'hA5, a); chk(a == 1'b0, "R6 data ack", int'(a), 0);
        m_write(8'h3C, a);
        m_write(8'hE7, a);
        m_stop;
        chk(regs[8'h10] == 8'hA5, "R6 first byte at pointer", int'(regs[8'h10]), 'hA5);
        chk(regs[8'h11] == 8'h3C, "R6 second byte advanced", int'(regs[8'h11]), 'h3C);
        chk(regs[8'h12] == 8'hE7, "R6 third byte advanced", int'(regs[8'h12]), 'hE7);
        chk(we_cnt - w0 == 3, "R9 one strobe per byte", we_cnt - w0, 3);
    endtask

    task automatic t_addr_miss;
        logic a;
        int   w0;
        w0 = we_cnt;
        m_start;
        m_write(8'h9E, a); chk(a == 1'b1, "R3 no ack on mismatch", int'(a), 1);
        m_write(8'h20, a); chk(a == 1'b1, "R3 later byte ignored", int'(a), 1);
        m_write(8'h99, a);
        m_stop;
        chk(we_cnt == w0, "R3 no write after mismatch", we_cnt - w0, 0);
        chk(regs[8'h20] == (8'h20 ^ 8'h5A), "R3 register untouched",
            int'(regs[8'h20]), int'(8'h20 ^ 8'h5A));
    endtask

    task automatic t_cmd_then_read;
        logic       a;
        logic [7:0] d;
        int         w0;
        w0 = we_cnt;
        m_start;
        m_write(8'h9C, a);
        m_write(8'h30, a);
        m_stop;
        chk(we_cnt == w0, "R5 pointer-only write stores nothing", we_cnt - w0, 0);
        m_start;
        m_write(8'h9D, a); chk(a == 1'b0, "R2 read address ack", int'(a), 0);
        m_read(1'b0, d); chk(d == (8'h30 ^ 8'h5A), "R7 read at stored pointer", int'(d), int'(8'h30 ^ 8'h5A));
        m_read(1'b1, d); chk(d == (8'h31 ^ 8'h5A), "R7 read advances", int'(d), int'(8'h31 ^ 8'h5A));
        m_stop;
        m_start;
        m_write(8'h9D, a);
        m_read(1'b1, d); chk(d == (8'h32 ^ 8'h5A), "R7 pointer kept across reads", int'(d), int'(8'h32 ^ 8'h5A));
        m_stop;
    endtask

    task automatic t_wrap;
        logic       a;
        logic [7:0] d;
        m_start;
        m_write(8'h9C, a);
        m_write(8'hFF, a);
        m_write(8'h11, a);
        m_write(8'h22, a);
        m_stop;
        chk(regs[8'hFF] == 8'h11, "R6 write at 0xFF", int'(regs[8'hFF]), 'h11);
        chk(regs[8'h00] == 8'h22, "R6 pointer wraps to 0x00", int'(regs[8'h00]), 'h22);
        m_start;
        m_write(8'h9D, a);
        m_read(1'b1, d); chk(d == (8'h01 ^ 8'h5A), "R7 read after wrap", int'(d), int'(8'h01 ^ 8'h5A));
        m_stop;
    endtask

    task automatic t_repeated_start;
        logic       a;
        logic [7:0] d;
        m_start;
        m_write(8'h9C, a);
        m_write(8'h40, a);
        m_start;
        m_write(8'h9D, a); chk(a == 1'b0, "R8 ack after repeated start", int'(a), 0);
        m_read(1'b0, d); chk(d == (8'h40 ^ 8'h5A), "R8 read at new pointer", int'(d), int'(8'h40 ^ 8'h5A));
        m_read(1'b1, d); chk(d == (8'h41 ^ 8'h5A), "R8 read continues", int'(d), int'(8'h41 ^ 8'h5A));
        m_stop;
    endtask

    task automatic t_pins(input logic [1:0] c1, input logic [1:0] c0);
        logic       a;
        logic [7:0] good, bad;
        do_reset(c1, c0);
        good = {3'b100, c1, c0, 1'b0};
        bad  = good ^ 8'h08;
        m_start;
        m_write(bad, a); chk(a == 1'b1, "R4 other code not matched", int'(a), 1);
        m_stop;
        m_start;
        m_write(good, a); chk(a == 1'b0, "R4 decoded address acked", int'(a), 0);
        m_stop;
    endtask

    initial begin
        do_reset(2'd3, 2'd2);
        t_reset_state;
        t_write_burst;
        t_addr_miss;
        t_cmd_then_read;
        t_wrap;
        t_repeated_start;
        t_pins(2'd0, 2'd1);
        t_pins(2'd2, 2'd0);
        t_pins(2'd1, 2'd3);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule